// File: doc/BRIEF.md
# UART Interrupt Register Bank

This block keeps the pending and enable state for the four interrupt sources of a UART: transmit watermark, receive watermark, transmit empty and receive overflow. Neighbouring transmit and receive logic drives one level event input per source. Any cycle in which an event is high latches its pending bit, and the bit stays set until software clears it. Each source drives its own level interrupt line. That line is high while the pending bit and the matching enable bit are both set.

Software reaches the block through a simple 32-bit register port with 4-byte accesses. The byte address is turned into a word index by dropping its two low bits. The port has three registers:

- Word 0 is the pending register. A write clears each pending bit that is written as 1.
- Word 1 is the enable register. It can be read and written.
- Word 2 is a write-only test register. A write forces pending bits to 1, so software can raise any interrupt to exercise its handler.

Reads are combinational on the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `uirq_regs`

## Requirements
- R1: Source bit positions are fixed: bit 0 transmit watermark, bit 1 receive watermark, bit 2 transmit empty, bit 3 receive overflow. A high `evt_in[i]` at a clock edge sets pending bit i, and the bit stays set after the event drops.
- R2: `irq_out[i]` is high exactly when pending bit i and enable bit i are both 1. It follows a register write in the cycle after the write edge.
- R3: A write to word 0 clears every pending bit whose data bit is 1 and leaves the other pending bits unchanged.
- R4: A write to word 2 ORs data bits 3:0 into the pending bits. A read of word 2 returns zero.
- R5: A write to word 1 loads data bits 3:0 into the enable register. A read of word 1 returns the enable bits in bits 3:0 and zero above them.
- R6: Synchronous active-low reset clears pending and enable, so every interrupt line is low after reset.
- R7: The word index is the byte address shifted right by 2. Address bits 1:0 do not affect which register is accessed.
- R8: When an event input and a clear of the same bit arrive in the same cycle, the event wins and the pending bit stays 1.
- R9: A word index other than 0, 1 or 2 reads as zero, and a write to it changes neither pending nor enable.
- R10: A read of word 0 returns the pending bits in bits 3:0 and zero above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one register access |
| bus_addr | input | ADDR_W (10) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| evt_in | input | NUM_SRC (4) | Level event input per source |
| irq_out | output | NUM_SRC (4) | Level interrupt output per source |

## Verification
The assertions assume that a write strobe covers exactly one clock edge per access, and that the event inputs are already synchronous to `clk`. The stimulus changes every input only on the falling edge. Each write is held for exactly one cycle, and the idle and read cycles between writes keep the strobe low. Event, clear and test patterns are drawn across all four bits, including clears and events that land on the same bit in the same cycle, so the event-wins rule is exercised under both directed and random traffic.

// File: rtl/uirq_pkg.sv
// Shared constants for the UART interrupt register bank.
// Assumes word-addressed 32-bit registers; word indices are software-visible.
package uirq_pkg;
    localparam int NUM_SRC    = 4;
    localparam int DATA_W     = 32;
    // Word indices of the three registers
    localparam int WORD_PEND  = 0;
    localparam int WORD_ENAB  = 1;
    localparam int WORD_FORCE = 2;
    // Source bit positions
    localparam int SRC_TX_WMARK = 0;
    localparam int SRC_RX_WMARK = 1;
    localparam int SRC_TX_EMPTY = 2;
    localparam int SRC_RX_OVF   = 3;
endpackage

// File: rtl/uirq_decode.sv
// Address decoder: turns a byte address into register selects and write strobes.
// Assumes 4-byte accesses; address bits 1:0 are dropped.
module uirq_decode #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              sel_pend_o,
    output logic              sel_enab_o,
    output logic              wr_pend_o,
    output logic              wr_enab_o,
    output logic              wr_force_o
);
    import uirq_pkg::*;

    logic [ADDR_W-1:0] word_idx;
    logic              sel_force;

    // Derive the word index and compare it against each register
    always_comb begin
        word_idx   = addr_i >> 2;
        sel_pend_o = (word_idx == ADDR_W'(WORD_PEND));
        sel_enab_o = (word_idx == ADDR_W'(WORD_ENAB));
        sel_force  = (word_idx == ADDR_W'(WORD_FORCE));
        wr_pend_o  = wr_i && sel_pend_o;
        wr_enab_o  = wr_i && sel_enab_o;
        wr_force_o = wr_i && sel_force;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_pend_o, wr_enab_o, wr_force_o})); // R7
    AST_NO_STROBE_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i >> 2) > ADDR_W'(WORD_FORCE) |-> !(wr_pend_o || wr_enab_o || wr_force_o)); // R9
endmodule

// File: rtl/uirq_cell.sv
// One interrupt source: sticky pending bit, enable bit and gated output.
// Assumes event, clear and force inputs are synchronous to clk.
module uirq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    input  logic force_i,
    input  logic en_wr_i,
    input  logic en_d_i,
    output logic pend_o,
    output logic en_o,
    output logic irq_o
);
    logic pend_q;
    logic en_q;

    // Pending bit: clear first, then force and event set (event beats clear)
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q && !clr_i) || force_i || evt_i;
    end

    // Enable bit: loaded on a write to the enable register
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (en_wr_i) en_q <= en_d_i;
    end

    // Output gating
    always_comb begin
        pend_o = pend_q;
        en_o   = en_q;
        irq_o  = pend_q && en_q;
    end

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !evt_i && !force_i |=> !pend_o); // R3
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> pend_o); // R8
    AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> pend_o); // R4
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o && !clr_i |=> pend_o); // R1
    AST_ENAB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> en_o == $past(en_d_i)); // R5
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i && !en_d_i |=> !irq_o); // R2
endmodule

// File: rtl/uirq_regs.sv
// UART interrupt register bank top: pending (W1C), enable (RW), force (WO).
// Assumes one-cycle write strobes and event inputs synchronous to clk.
module uirq_regs #(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = uirq_pkg::DATA_W,
    parameter int NUM_SRC = uirq_pkg::NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic [NUM_SRC-1:0] irq_out
);
    localparam int PAD_W = DATA_W - NUM_SRC;

    logic               sel_pend, sel_enab;
    logic               wr_pend, wr_enab, wr_force;
    logic [NUM_SRC-1:0] pend_vec, en_vec;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

    uirq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .sel_pend_o (sel_pend),
        .sel_enab_o (sel_enab),
        .wr_pend_o  (wr_pend),
        .wr_enab_o  (wr_enab),
        .wr_force_o (wr_force)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        uirq_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_in[i]),
            .clr_i   (wr_pend && bus_wdata[i]),
            .force_i (wr_force && bus_wdata[i]),
            .en_wr_i (wr_enab),
            .en_d_i  (bus_wdata[i]),
            .pend_o  (pend_vec[i]),
            .en_o    (en_vec[i]),
            .irq_o   (irq_out[i])
        );
    end

    // Read mux: force register and unmapped words read as zero
    always_comb begin
        if (sel_pend)      bus_rdata = {{PAD_W{1'b0}}, pend_vec};
        else if (sel_enab) bus_rdata = {{PAD_W{1'b0}}, en_vec};
        else               bus_rdata = '0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> irq_out == '0); // R6
    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_SRC] == '0); // R10
endmodule

// File: tb/uirq_regs_tb.sv
module uirq_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        d_wr = 1'b0;
    logic [9:0]  d_addr = '0;
    logic [31:0] d_wdata = '0;
    logic [3:0]  d_evt = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string tag = "R6";

    // behavioural reference state
    logic [3:0] m_pend = '0;
    logic [3:0] m_en = '0;

    always #10 clk = ~clk;

    uirq_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(d_wr), .bus_addr(d_addr),
        .bus_wdata(d_wdata), .bus_rdata(bus_rdata), .evt_in(d_evt), .irq_out(irq_out)
    );

    always @(posedge clk) begin
        int w;
        w = int'(d_addr >> 2);
        if (!rst_n) begin
            m_pend = '0;
            m_en   = '0;
        end else begin
            logic [3:0] nx;
            nx = m_pend;
            if (d_wr && w == 0) nx = nx & ~d_wdata[3:0];
            if (d_wr && w == 2) nx = nx | d_wdata[3:0];
            nx = nx | d_evt;
            if (d_wr && w == 1) m_en = d_wdata[3:0];
            m_pend = nx;
        end
    end

    task automatic compare();
        logic [31:0] exp_rd;
        int w;
        w = int'(d_addr >> 2);
        exp_rd = (w == 0) ? {28'd0, m_pend} : (w == 1) ? {28'd0, m_en} : 32'd0;
        n_cmp++;
        if (irq_out !== (m_pend & m_en)) begin
            n_bad++;
            $display("FAIL %s irq_out actual=%h expected=%h", tag, irq_out, m_pend & m_en);
        end
        n_cmp++;
        if (bus_rdata !== exp_rd) begin
            n_bad++;
            $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, d_addr, bus_rdata, exp_rd);
        end
    endtask

    task automatic cyc(input logic wr, input logic [9:0] a, input logic [31:0] d, input logic [3:0] e);
        @(negedge clk);
        compare();
        d_wr = wr; d_addr = a; d_wdata = d; d_evt = e;
    endtask

    task automatic rd(input logic [9:0] a);
        cyc(1'b0, a, 32'd0, 4'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R6";
        rd(10'h000); rd(10'h004);
        @(negedge clk); rst_n = 1'b1;
        rd(10'h000); rd(10'h004);
        tag = "R1";
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 10'h000, 32'd0, 4'(1 << i));
            rd(10'h000);
        end
        rd(10'h000);
        tag = "R5";
        cyc(1'b1, 10'h004, 32'hFFFF_FFFF, 4'd0);
        rd(10'h004);
        tag = "R2";
        cyc(1'b1, 10'h004, 32'h0000_0005, 4'd0);
        rd(10'h004);
        tag = "R3";
        cyc(1'b1, 10'h000, 32'h0000_0006, 4'd0);
        rd(10'h000);
        cyc(1'b1, 10'h000, 32'hFFFF_FFFF, 4'd0);
        rd(10'h000);
        tag = "R4";
        cyc(1'b1, 10'h008, 32'h0000_000A, 4'd0);
        rd(10'h008); rd(10'h000);
        cyc(1'b1, 10'h008, 32'hFFFF_FFF1, 4'd0);
        rd(10'h000);
        tag = "R8";
        cyc(1'b1, 10'h000, 32'h0000_000F, 4'b0100);
        rd(10'h000);
        tag = "R7";
        cyc(1'b1, 10'h007, 32'h0000_0003, 4'd0);
        rd(10'h005); rd(10'h003); rd(10'h00B);
        tag = "R9";
        cyc(1'b1, 10'h00C, 32'hFFFF_FFFF, 4'd0);
        cyc(1'b1, 10'h3FC, 32'h0000_0000, 4'd0);
        rd(10'h00C); rd(10'h3FC); rd(10'h000); rd(10'h004);
        tag = "R10";
        for (int k = 0; k < 400; k++) begin
            logic [9:0] a;
            a = 10'($urandom_range(0, 4) << 2) | 10'($urandom_range(0, 3));
            cyc(1'($urandom_range(0, 1)), a, $urandom, 4'($urandom & $urandom));
        end
        rd(10'h000);
        rd(10'h004);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired during %s", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule